// File: doc/BRIEF.md
# SDR SDRAM Command Sequencer

This block sits between a client that issues single-word memory requests and a four-bank single-data-rate synchronous DRAM with a 64-bit data bus. After reset it brings the memory up with a fixed start-up sequence. It then turns each accepted request into the activate, precharge and column commands that request needs. Any row it opens stays open until another row of that bank is wanted or a refresh is due.

Every command is held back until the minimum spacing to earlier commands has passed. Each spacing is a parameter counted in clocks, and the defaults suit a 133 MHz clock with a read latency of 3. The block also counts out the refresh interval. When a refresh is due it takes precedence over waiting requests: the block closes all open rows and then issues an auto refresh. Read data returns with a one-clock valid strobe, and the byte-mask outputs are timed so that they do not suppress the read data.

Top module: `sdram_seq`

## Requirements
- R1: While reset is asserted, cke is 0, cs_n is 1 and req_ready is 0. After reset, and before any column command, the first four commands are: precharge with a[10]=1, auto refresh, auto refresh, mode-register set with a = CL<<4 (a[2:0]=0 single-word burst, a[3]=0 sequential order). A command is decoded with cs_n low as {ras_n,cas_n,we_n}: 011 activate, 101 read, 100 write, 010 precharge, 001 refresh, 000 mode set, 111 no operation.
- R2: A read or write is issued only to a bank that is open, and no sooner than T_RCD clocks after that bank's activate.
- R3: An activate is issued no sooner than T_RP clocks after the last precharge of its bank, and an auto refresh is issued no sooner than T_RP clocks after the last precharge of any bank.
- R4: A bank is precharged no sooner than T_RAS clocks after its activate, and it is activated again no sooner than T_RC clocks after its previous activate.
- R5: Two activates, to any banks, are at least T_RRD clocks apart.
- R6: A bank is precharged no sooner than T_WR clocks after the last write to it.
- R7: No command other than no operation is issued within T_MRD clocks after a mode set or within T_RFC clocks after an auto refresh.
- R8: Auto refresh and mode set are issued only while every bank is closed.
- R9: In normal operation, successive auto refreshes are no more than REF_INT+60 clocks apart.
- R10: A request that hits the open row of its bank is served with no activate. A request to a different row of an open bank causes one single-bank precharge (a[10]=0) and then one activate. An accepted request (req_valid and req_ready both high) appears as a column command on the following clock.
- R11: A write drives dq_oe=1 and the write data on dq_out with the command. dqm bit i is the inverse of be bit i, where be bit i enables byte i (data bits 8i+7..8i). A write with be=0 leaves the stored word unchanged.
- R12: The read result appears on rd_data with rd_valid high for exactly one clock. This happens CL clocks after the memory samples the read command, and read results come back in request order. dqm is 0 in the clock CL-2 after the read command, so the data is not masked, and no write is issued until the read data has left the bus.
- R13: When a refresh falls due with rows open, all banks are precharged (a[10]=1) before the refresh. A row left open before that refresh is reopened afterwards on demand and returns its stored data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted this clock |
| req_write | input | 1 | 1 = write, 0 = read |
| req_bank | input | 2 | Bank of the request |
| req_row | input | 13 | Row of the request |
| req_col | input | 10 | Column of the request |
| req_wdata | input | 64 | Write data |
| req_be | input | 8 | Byte enables, bit i for byte i |
| rd_data | output | 64 | Read result |
| rd_valid | output | 1 | Read result strobe |
| sd_cke | output | 1 | Memory clock enable |
| sd_cs_n | output | 1 | Memory select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_ba | output | 2 | Bank address |
| sd_a | output | 13 | Multiplexed address |
| sd_dqm | output | 8 | Byte masks, 1 = masked |
| sd_dq_out | output | 64 | Data toward memory |
| sd_dq_oe | output | 1 | Data output enable |
| sd_dq_in | input | 64 | Data from memory |

## Verification
The case hardest to reach from the ports is a refresh falling due while rows are open and requests are still arriving. The block must then close every bank, honour the active and write-recovery times, refresh, and reopen rows without breaking any spacing rule. The bench reaches this case in two ways. In the first, it leaves a row open and idles for more than two refresh intervals. In the second, it drives a long stream of mixed requests over many banks and rows, with write/read alternations that are computed rather than random; the stream is longer than one refresh interval. A behavioural memory in the bench checks every spacing rule and stores the data. Read-backs are compared against a shadow copy that the bench builds from the requests.

// File: rtl/sdram_seq.sv
module sdram_seq #(
  parameter int CL        = 3,
  parameter int T_RCD     = 3,
  parameter int T_RP      = 3,
  parameter int T_RAS     = 6,
  parameter int T_RC      = 9,
  parameter int T_RRD     = 2,
  parameter int T_WR      = 2,
  parameter int T_MRD     = 2,
  parameter int T_RFC     = 9,
  parameter int REF_INT   = 1040,
  parameter int INIT_WAIT = 20,
  parameter int ROW_W     = 13,
  parameter int COL_W     = 10,
  parameter int DATA_W    = 64
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [1:0]        req_bank,
  input  logic [ROW_W-1:0]  req_row,
  input  logic [COL_W-1:0]  req_col,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [DATA_W/8-1:0] req_be,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid,
  output logic              sd_cke,
  output logic              sd_cs_n,
  output logic              sd_ras_n,
  output logic              sd_cas_n,
  output logic              sd_we_n,
  output logic [1:0]        sd_ba,
  output logic [ROW_W-1:0]  sd_a,
  output logic [DATA_W/8-1:0] sd_dqm,
  output logic [DATA_W-1:0] sd_dq_out,
  output logic              sd_dq_oe,
  input  logic [DATA_W-1:0] sd_dq_in
);
  localparam int CW = $clog2(T_RC + T_RAS + T_RCD + T_RP + T_RRD + T_WR + 2);
  localparam int WW = $clog2(INIT_WAIT + T_RFC + T_MRD + 2);
  localparam int RW = $clog2(REF_INT + 1);
  localparam logic [CW-1:0] CMAX  = '1;
  localparam logic [CW-1:0] K_RCD = CW'(T_RCD);
  localparam logic [CW-1:0] K_RP  = CW'(T_RP);
  localparam logic [CW-1:0] K_RAS = CW'(T_RAS);
  localparam logic [CW-1:0] K_RC  = CW'(T_RC);
  localparam logic [CW-1:0] K_RRD = CW'(T_RRD);
  localparam logic [CW-1:0] K_WR  = CW'(T_WR);
  localparam logic [2:0] C_NOP = 3'b111, C_ACT = 3'b011, C_RD = 3'b101, C_WR = 3'b100,
                         C_PRE = 3'b010, C_REF = 3'b001, C_MRS = 3'b000;

  typedef enum logic [2:0] {I_PALL, I_REF1, I_REF2, I_MRS, RUN} st_t;

  st_t              st, st_n;
  logic [WW-1:0]    wait_q, wait_n;
  logic [3:0]       open_q;
  logic [ROW_W-1:0] row_q [4];
  logic [CW-1:0]    act_c [4];
  logic [CW-1:0]    pre_c [4];
  logic [CW-1:0]    wr_c  [4];
  logic [CW-1:0]    rrd_c;
  logic [RW-1:0]    ref_c;
  logic             ref_pend, ref_clr;
  logic [CL:0]      rd_pipe;
  logic [CL:0]      rq_vec;
  logic [2:0]       cmd_n;
  logic [ROW_W-1:0] a_n;
  logic             hit, rd_busy, pall_ok, quiet_ok;
  logic             is_act, is_rd, is_wr, is_pre, pre_all;

  assign hit       = open_q[req_bank] && (row_q[req_bank] == req_row);
  assign rd_busy   = |rd_pipe[CL-2:0];
  assign req_ready = req_valid && !ref_pend && st == RUN && wait_q == '0 && hit &&
                     act_c[req_bank] >= K_RCD && !(req_write && rd_busy);

  always_comb begin
    pall_ok  = 1'b1;
    quiet_ok = 1'b1;
    for (int i = 0; i < 4; i++) begin
      if (open_q[i] && (act_c[i] < K_RAS || wr_c[i] < K_WR)) pall_ok = 1'b0;
      if (pre_c[i] < K_RP) quiet_ok = 1'b0;
    end
  end

  always_comb begin
    cmd_n   = C_NOP;
    a_n     = '0;
    st_n    = st;
    wait_n  = (wait_q == '0) ? '0 : wait_q - WW'(1);
    ref_clr = 1'b0;
    if (wait_q == '0) begin
      case (st)
        I_PALL: begin cmd_n = C_PRE; a_n[10] = 1'b1; st_n = I_REF1; end
        I_REF1: if (quiet_ok) begin cmd_n = C_REF; wait_n = WW'(T_RFC - 1); st_n = I_REF2; end
        I_REF2: begin cmd_n = C_REF; wait_n = WW'(T_RFC - 1); st_n = I_MRS; end
        I_MRS:  begin cmd_n = C_MRS; a_n = ROW_W'(CL << 4); wait_n = WW'(T_MRD - 1); st_n = RUN; end
        default: begin
          if (ref_pend) begin
            if (open_q != '0) begin
              if (pall_ok) begin cmd_n = C_PRE; a_n[10] = 1'b1; end
            end else if (quiet_ok) begin
              cmd_n = C_REF; wait_n = WW'(T_RFC - 1); ref_clr = 1'b1;
            end
          end else if (req_valid) begin
            if (req_ready) begin
              cmd_n = req_write ? C_WR : C_RD;
              a_n[COL_W-1:0] = req_col;
            end else if (open_q[req_bank] && !hit) begin
              if (act_c[req_bank] >= K_RAS && wr_c[req_bank] >= K_WR) cmd_n = C_PRE;
            end else if (!open_q[req_bank]) begin
              if (pre_c[req_bank] >= K_RP && act_c[req_bank] >= K_RC && rrd_c >= K_RRD) begin
                cmd_n = C_ACT; a_n = req_row;
              end
            end
          end
        end
      endcase
    end
  end

  assign is_act  = cmd_n == C_ACT;
  assign is_rd   = cmd_n == C_RD;
  assign is_wr   = cmd_n == C_WR;
  assign is_pre  = cmd_n == C_PRE;
  assign pre_all = is_pre && a_n[10];
  assign rq_vec  = {rd_pipe[CL-1:0], is_rd};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= I_PALL; wait_q <= WW'(INIT_WAIT);
      open_q <= '0; rrd_c <= CMAX; ref_c <= '0; ref_pend <= 1'b0; rd_pipe <= '0;
      for (int i = 0; i < 4; i++) begin
        row_q[i] <= '0; act_c[i] <= CMAX; pre_c[i] <= CMAX; wr_c[i] <= CMAX;
      end
      sd_cke <= 1'b0; sd_cs_n <= 1'b1; {sd_ras_n, sd_cas_n, sd_we_n} <= C_NOP;
      sd_ba <= '0; sd_a <= '0; sd_dqm <= '1; sd_dq_out <= '0; sd_dq_oe <= 1'b0;
      rd_valid <= 1'b0; rd_data <= '0;
    end else begin
      st <= st_n;
      wait_q <= wait_n;
      sd_cke <= 1'b1;
      sd_cs_n <= 1'b0;
      {sd_ras_n, sd_cas_n, sd_we_n} <= cmd_n;
      sd_ba <= req_bank;
      sd_a <= a_n;
      sd_dqm <= is_wr ? ~req_be : (rq_vec[CL-2] ? '0 : '1);
      sd_dq_oe <= is_wr;
      if (is_wr) sd_dq_out <= req_wdata;
      for (int i = 0; i < 4; i++) begin
        if (is_act && req_bank == 2'(i)) begin
          act_c[i] <= CW'(1); open_q[i] <= 1'b1; row_q[i] <= req_row;
        end else if (act_c[i] != CMAX) act_c[i] <= act_c[i] + CW'(1);
        if (pre_all || (is_pre && req_bank == 2'(i))) begin
          pre_c[i] <= CW'(1); open_q[i] <= 1'b0;
        end else if (pre_c[i] != CMAX) pre_c[i] <= pre_c[i] + CW'(1);
        if (is_wr && req_bank == 2'(i)) wr_c[i] <= CW'(1);
        else if (wr_c[i] != CMAX) wr_c[i] <= wr_c[i] + CW'(1);
      end
      if (is_act) rrd_c <= CW'(1);
      else if (rrd_c != CMAX) rrd_c <= rrd_c + CW'(1);
      if (ref_clr) ref_pend <= 1'b0;
      if (st == RUN) begin
        if (ref_c == RW'(REF_INT - 1)) begin ref_c <= '0; ref_pend <= 1'b1; end
        else ref_c <= ref_c + RW'(1);
      end
      rd_pipe <= {rd_pipe[CL-1:0], is_rd};
      rd_valid <= rd_pipe[CL];
      if (rd_pipe[CL]) rd_data <= sd_dq_in;
    end
  end
endmodule

// File: rtl/sdram_seq_chk.sv
module sdram_seq_chk #(
  parameter int CL    = 3,
  parameter int T_RCD = 3,
  parameter int T_RRD = 2,
  parameter int T_MRD = 2
)(
  input logic       clk,
  input logic       rst_n,
  input logic       sd_cs_n,
  input logic       sd_ras_n,
  input logic       sd_cas_n,
  input logic       sd_we_n,
  input logic [1:0] sd_ba,
  input logic       sd_a10,
  input logic       rd_valid,
  input logic       req_valid,
  input logic       req_ready
);
  logic [2:0] cmd;
  logic       c_act, c_rd, c_wr, c_pre, c_ref, c_mrs, c_nop;
  logic [4:0] since_act [4];
  logic [4:0] since_any, since_mrs;
  logic [3:0] open_t;

  assign cmd   = {sd_ras_n, sd_cas_n, sd_we_n};
  assign c_nop = sd_cs_n || cmd == 3'b111;
  assign c_act = !sd_cs_n && cmd == 3'b011;
  assign c_rd  = !sd_cs_n && cmd == 3'b101;
  assign c_wr  = !sd_cs_n && cmd == 3'b100;
  assign c_pre = !sd_cs_n && cmd == 3'b010;
  assign c_ref = !sd_cs_n && cmd == 3'b001;
  assign c_mrs = !sd_cs_n && cmd == 3'b000;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 4; i++) since_act[i] <= '1;
      since_any <= '1; since_mrs <= '1; open_t <= '0;
    end else begin
      for (int i = 0; i < 4; i++) begin
        if (c_act && sd_ba == 2'(i)) begin since_act[i] <= 5'd1; open_t[i] <= 1'b1; end
        else if (since_act[i] != '1) since_act[i] <= since_act[i] + 5'd1;
        if (c_pre && (sd_a10 || sd_ba == 2'(i))) open_t[i] <= 1'b0;
      end
      if (c_act) since_any <= 5'd1;
      else if (since_any != '1) since_any <= since_any + 5'd1;
      if (c_mrs) since_mrs <= 5'd1;
      else if (since_mrs != '1) since_mrs <= since_mrs + 5'd1;
    end
  end

  AST_ACT_TO_COL: assert property (@(posedge clk) disable iff (!rst_n)
    (c_rd || c_wr) |-> (open_t[sd_ba] && since_act[sd_ba] >= 5'(T_RCD))); // R2
  AST_ACT_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
    c_act |-> since_any >= 5'(T_RRD)); // R5
  AST_MODE_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    (since_mrs < 5'(T_MRD)) |-> c_nop); // R7
  AST_ALL_CLOSED: assert property (@(posedge clk) disable iff (!rst_n)
    (c_ref || c_mrs) |-> open_t == 4'b0); // R8
  AST_READ_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> $past(c_rd, CL + 1)); // R12
  AST_ACCEPT_COLUMN: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> (c_rd || c_wr)); // R10
endmodule

bind sdram_seq sdram_seq_chk #(.CL(CL), .T_RCD(T_RCD), .T_RRD(T_RRD), .T_MRD(T_MRD)) u_chk (
  .clk(clk), .rst_n(rst_n), .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n), .sd_cas_n(sd_cas_n),
  .sd_we_n(sd_we_n), .sd_ba(sd_ba), .sd_a10(sd_a[10]), .rd_valid(rd_valid),
  .req_valid(req_valid), .req_ready(req_ready));

// File: tb/test_sdram_seq.sv
module test_sdram_seq;
  localparam int CL = 3, T_RCD = 3, T_RP = 3, T_RAS = 6, T_RC = 9, T_RRD = 2;
  localparam int T_WR = 2, T_MRD = 2, T_RFC = 9, REF_INT = 1040;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_write = 0;
  logic [1:0] req_bank = 0;
  logic [12:0] req_row = 0;
  logic [9:0] req_col = 0;
  logic [63:0] req_wdata = 0;
  logic [7:0] req_be = 0;
  logic req_ready, rd_valid, sd_cke, sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n, sd_dq_oe;
  logic [63:0] rd_data, sd_dq_out;
  logic [63:0] sd_dq_in = 0;
  logic [1:0] sd_ba;
  logic [12:0] sd_a;
  logic [7:0] sd_dqm;

  sdram_seq i_sdram_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_bank(req_bank), .req_row(req_row), .req_col(req_col),
    .req_wdata(req_wdata), .req_be(req_be), .rd_data(rd_data), .rd_valid(rd_valid),
    .sd_cke(sd_cke), .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n), .sd_cas_n(sd_cas_n),
    .sd_we_n(sd_we_n), .sd_ba(sd_ba), .sd_a(sd_a), .sd_dqm(sd_dqm),
    .sd_dq_out(sd_dq_out), .sd_dq_oe(sd_dq_oe), .sd_dq_in(sd_dq_in));

  always #10 clk = ~clk;

  int checks = 0, failures = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    end
    $finish;
  endtask

  // Behavioural memory with spacing checks
  int cyc = 0;
  int last_act [4] = '{-1000, -1000, -1000, -1000};
  int last_pre [4] = '{-1000, -1000, -1000, -1000};
  int last_wr  [4] = '{-1000, -1000, -1000, -1000};
  int last_any_act = -1000, last_ref = -1000, last_mrs = -1000;
  bit [3:0] open_m = 0;
  logic [12:0] orow [4];
  bit mrs_done = 0;
  int n_init = 0;
  logic [3:0] init_code [4];
  logic [12:0] mrs_a;
  int act_count = 0, pre_single = 0, pall_open = 0, ref_count = 0;
  logic [63:0] mem [longint];
  logic [63:0] rdq [int];
  logic [7:0] dqm_h [int];
  int rd_cyc_q [$];

  function automatic longint mkey(input logic [1:0] b, input logic [12:0] r, input logic [9:0] c);
    return longint'({b, r, c});
  endfunction

  always @(posedge clk) begin
    logic [2:0] cmd;
    logic [1:0] b;
    logic [63:0] v;
    logic [7:0] m;
    longint k;
    cyc = cyc + 1;
    dqm_h[cyc] = sd_dqm;
    cmd = {sd_ras_n, sd_cas_n, sd_we_n};
    b = sd_ba;
    if (rst_n && sd_cke && !sd_cs_n && cmd != 3'b111) begin
      chk(cyc - last_ref >= T_RFC, "R7 refresh gap", cyc - last_ref, T_RFC);
      chk(cyc - last_mrs >= T_MRD, "R7 mode gap", cyc - last_mrs, T_MRD);
      if (!mrs_done && n_init < 4) begin
        init_code[n_init] = {cmd, sd_a[10]};
        n_init++;
      end
      case (cmd)
        3'b011: begin
          chk(!open_m[b], "R10 activate of open bank", open_m[b], 0);
          chk(cyc - last_pre[b] >= T_RP, "R3 precharge to activate", cyc - last_pre[b], T_RP);
          chk(cyc - last_act[b] >= T_RC, "R4 row cycle", cyc - last_act[b], T_RC);
          chk(cyc - last_any_act >= T_RRD, "R5 activate spacing", cyc - last_any_act, T_RRD);
          last_act[b] = cyc; last_any_act = cyc; open_m[b] = 1; orow[b] = sd_a; act_count++;
        end
        3'b101, 3'b100: begin
          chk(mrs_done, "R1 column before mode set", mrs_done, 1);
          chk(open_m[b], "R2 column to closed bank", open_m[b], 1);
          chk(cyc - last_act[b] >= T_RCD, "R2 activate to column", cyc - last_act[b], T_RCD);
          k = mkey(b, orow[b], sd_a[9:0]);
          v = mem.exists(k) ? mem[k] : 64'h0;
          if (cmd == 3'b100) begin
            chk(sd_dq_oe, "R11 output enable on write", sd_dq_oe, 1);
            for (int j = 0; j < 8; j++) if (!sd_dqm[j]) v[8*j +: 8] = sd_dq_out[8*j +: 8];
            mem[k] = v;
            last_wr[b] = cyc;
          end else begin
            rdq[cyc + CL] = v;
            rd_cyc_q.push_back(cyc);
          end
        end
        3'b010: begin
          if (sd_a[10] && open_m != 0) pall_open++;
          if (!sd_a[10]) pre_single++;
          for (int i = 0; i < 4; i++) begin
            if (sd_a[10] || b == 2'(i)) begin
              if (open_m[i]) begin
                chk(cyc - last_act[i] >= T_RAS, "R4 activate to precharge", cyc - last_act[i], T_RAS);
                chk(cyc - last_wr[i] >= T_WR, "R6 write to precharge", cyc - last_wr[i], T_WR);
              end
              last_pre[i] = cyc; open_m[i] = 0;
            end
          end
        end
        3'b001: begin
          chk(open_m == 0, "R8 refresh with open bank", open_m, 0);
          for (int i = 0; i < 4; i++)
            chk(cyc - last_pre[i] >= T_RP, "R3 precharge to refresh", cyc - last_pre[i], T_RP);
          if (mrs_done) chk(cyc - last_ref <= REF_INT + 60, "R9 refresh interval", cyc - last_ref, REF_INT + 60);
          last_ref = cyc; ref_count++;
        end
        3'b000: begin
          chk(open_m == 0, "R8 mode set with open bank", open_m, 0);
          last_mrs = cyc; mrs_done = 1; mrs_a = sd_a;
        end
        default: ;
      endcase
    end
    if (rdq.exists(cyc + 1)) begin
      v = rdq[cyc + 1];
      m = dqm_h.exists(cyc - 1) ? dqm_h[cyc - 1] : 8'hFF;
      for (int j = 0; j < 8; j++) if (m[j]) v[8*j +: 8] = 8'hA5;
      sd_dq_in <= v;
    end else sd_dq_in <= 64'h0;
  end

  // Read result monitor against the bench's own shadow
  logic [63:0] exp_mem [longint];
  logic [63:0] exp_q [$];

  always @(negedge clk) begin
    if (rst_n && rd_valid) begin
      if (exp_q.size() == 0 || rd_cyc_q.size() == 0) begin
        chk(0, "R12 unexpected read strobe", 1, 0);
      end else begin
        chk(cyc == rd_cyc_q[0] + CL, "R12 read latency", cyc - rd_cyc_q[0], CL);
        chk(rd_data == exp_q[0], "R12 read data", rd_data, exp_q[0]);
        void'(exp_q.pop_front());
        void'(rd_cyc_q.pop_front());
      end
    end
  end

  task automatic do_req(input bit w, input logic [1:0] b, input logic [12:0] r,
                        input logic [9:0] c, input logic [63:0] d, input logic [7:0] be);
    bit got;
    int n;
    longint k;
    logic [63:0] v;
    @(negedge clk);
    req_valid = 1; req_write = w; req_bank = b; req_row = r; req_col = c;
    req_wdata = d; req_be = be;
    n = 0;
    forever begin
      #5 got = req_ready;
      @(posedge clk);
      if (got) break;
      n++;
      if (n > 3000) begin
        chk(0, "R10 request never accepted", 0, 1);
        break;
      end
    end
    k = mkey(b, r, c);
    v = exp_mem.exists(k) ? exp_mem[k] : 64'h0;
    if (w) begin
      for (int j = 0; j < 8; j++) if (be[j]) v[8*j +: 8] = d[8*j +: 8];
      exp_mem[k] = v;
    end else exp_q.push_back(v);
    @(negedge clk);
    req_valid = 0;
  endtask

  task automatic drain();
    for (int i = 0; i < 300 && exp_q.size() != 0; i++) @(negedge clk);
    chk(exp_q.size() == 0, "R12 reads outstanding", exp_q.size(), 0);
  endtask

  task automatic t_reset();
    rst_n = 0;
    repeat (3) @(negedge clk);
    chk(sd_cke == 0, "R1 cke in reset", sd_cke, 0);
    chk(sd_cs_n == 1, "R1 cs_n in reset", sd_cs_n, 1);
    chk(req_ready == 0, "R1 ready in reset", req_ready, 0);
  endtask

  task automatic t_init();
    rst_n = 1;
    do_req(1, 2'd0, 13'd0, 10'd0, 64'h0123_4567_89AB_CDEF, 8'hFF);
    chk(n_init == 4, "R1 init command count", n_init, 4);
    chk(init_code[0] == 4'b0101, "R1 first precharge-all", init_code[0], 4'b0101);
    chk(init_code[1][3:1] == 3'b001, "R1 first refresh", init_code[1][3:1], 3'b001);
    chk(init_code[2][3:1] == 3'b001, "R1 second refresh", init_code[2][3:1], 3'b001);
    chk(init_code[3][3:1] == 3'b000, "R1 mode set", init_code[3][3:1], 3'b000);
    chk(mrs_a == 13'(CL << 4), "R1 mode value", mrs_a, CL << 4);
    do_req(0, 2'd0, 13'd0, 10'd0, 0, 0);
    drain();
  endtask

  task automatic t_hit();
    int a0, p0;
    a0 = act_count;
    do_req(1, 2'd1, 13'd5, 10'd3, 64'hDEAD_BEEF_0000_1111, 8'hFF);
    do_req(0, 2'd1, 13'd5, 10'd3, 0, 0);
    do_req(0, 2'd1, 13'd5, 10'd4, 0, 0);
    drain();
    chk(act_count - a0 == 1, "R10 row hit needs no activate", act_count - a0, 1);
    a0 = act_count; p0 = pre_single;
    do_req(1, 2'd1, 13'd7, 10'd0, 64'h7777_0000_7777_0000, 8'hFF);
    do_req(0, 2'd1, 13'd5, 10'd3, 0, 0);
    drain();
    chk(act_count - a0 == 2, "R10 row miss activates", act_count - a0, 2);
    chk(pre_single - p0 == 2, "R10 row miss precharges one bank", pre_single - p0, 2);
  endtask

  task automatic t_banks();
    for (int i = 0; i < 4; i++)
      do_req(1, 2'(i), 13'(20 + i), 10'(i), {32'(i), 32'hC0DE_0000 + 32'(i)}, 8'hFF);
    for (int i = 0; i < 4; i++) do_req(0, 2'(i), 13'(20 + i), 10'(i), 0, 0);
    drain();
  endtask

  task automatic t_mask();
    do_req(1, 2'd2, 13'd30, 10'd8, 64'h1111_1111_1111_1111, 8'hFF);
    do_req(1, 2'd2, 13'd30, 10'd8, 64'hFFFF_FFFF_FFFF_FFFF, 8'h0F);
    do_req(1, 2'd2, 13'd30, 10'd8, 64'h2222_2222_2222_2222, 8'h00);
    do_req(0, 2'd2, 13'd30, 10'd8, 0, 0);
    drain();
    chk(exp_mem[mkey(2'd2, 13'd30, 10'd8)] == 64'h1111_1111_FFFF_FFFF, "R11 shadow merge",
        exp_mem[mkey(2'd2, 13'd30, 10'd8)], 64'h1111_1111_FFFF_FFFF);
  endtask

  task automatic t_refresh();
    int r0, p0;
    r0 = ref_count; p0 = pall_open;
    do_req(1, 2'd3, 13'd40, 10'd1, 64'hABCD_0123_4567_9876, 8'hFF);
    repeat (2 * REF_INT + 100) @(negedge clk);
    chk(ref_count - r0 >= 2, "R9 refreshes while idle", ref_count - r0, 2);
    chk(pall_open > p0, "R13 rows closed before refresh", pall_open - p0, 1);
    do_req(0, 2'd3, 13'd40, 10'd1, 0, 0);
    drain();
  endtask

  task automatic t_stream();
    logic [15:0] x;
    int p0;
    x = 16'hACE1;
    p0 = pall_open;
    for (int n = 0; n < 160; n++) begin
      x = {x[14:0], x[15] ^ x[13] ^ x[12] ^ x[10]};
      do_req(x[8], x[1:0], 13'(x[4:2]), 10'(x[7:5]), {x, ~x, x ^ 16'h5A5A, 16'(n)},
             x[15:8] | 8'h81);
    end
    drain();
    chk(cyc - last_ref <= REF_INT + 60, "R9 refresh kept under traffic", cyc - last_ref, REF_INT + 60);
    chk(pall_open > p0, "R13 refresh closed rows under traffic", pall_open - p0, 1);
  endtask

  initial begin
    #(20 * 150000);
    failures++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    t_reset();
    t_init();
    t_hit();
    t_banks();
    t_mask();
    t_refresh();
    t_stream();
    repeat (10) @(negedge clk);
    summary();
  end
endmodule